// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is a serial slave that listens to a host microcontroller. The host lowers an active-low select line and shifts one 16-bit word on a data line, one bit per clock, most significant bit first. It then raises the select line again. The receiver splits each word into a 4-bit opcode in the top bits and a 12-bit operand below it. When the select line is released, the receiver publishes both fields with a one-cycle valid strobe.

One opcode is the configuration write. For that opcode, the low operand bits are loaded into a mode register and a second strobe pulses. The mode register resets to the "off" value 0x00. The host writes that value to return the attached logic to idle.

The serial clock, data and select inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser. The system clock must run at least four times faster than the serial clock. The serial clock idles low. Data is taken on its rising edge and may change on its falling edge. A select window that does not hold exactly 16 rising edges is thrown away.

Top module: `cmd_word_rx`

## Requirements
- R1: After reset, modeOut is 0x00 (the off value), cmdOut and dataOut are zero, and wordValid and cfgStrobe are low.
- R2: Bits are taken on rising serial-clock edges while csnIn is low, first bit as bit 15. After a valid word, cmdOut holds bits 15:12 and dataOut holds bits 11:0.
- R3: For a valid word, wordValid is high for exactly one system cycle. In that cycle, cmdOut and dataOut first show the new word. That cycle is the third system clock edge after the first edge that samples csnIn high.
- R4: A select window with fewer or more than 16 rising serial-clock edges produces no wordValid and no cfgStrobe, and cmdOut, dataOut and modeOut keep their values.
- R5: A valid word with opcode 0x1 loads modeOut from operand bits 7:0. cfgStrobe pulses in the same cycle as wordValid.
- R6: A valid word with any opcode other than 0x1 pulses wordValid but leaves modeOut unchanged and cfgStrobe low.
- R7: Serial-clock edges while csnIn is high are neither shifted nor counted. The next window decodes only its own bits.
- R8: cmdOut and dataOut change only in a cycle where wordValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from host, idles low |
| mosiIn | input | 1 | Serial data from host |
| csnIn | input | 1 | Active-low word select from host |
| cmdOut | output | 4 | Opcode of the last valid word |
| dataOut | output | 12 | Operand of the last valid word |
| modeOut | output | 8 | Mode register, 0x00 is off |
| wordValid | output | 1 | One-cycle strobe for a new word |
| cfgStrobe | output | 1 | One-cycle strobe for a mode register load |

## Verification
The hardest cases to produce from the ports are the discarded windows. Windows of 15 and 17 edges differ from a good word by a single serial clock, and the bench drives both. The bench also toggles the serial clock while select is high, then sends a good word. Only a counter that was correctly cleared and held decodes that word right. The stimulus steps the serial clock every four system cycles, so both synchronised edges fall on known cycles. A behavioural model runs three cycles behind the raw pins and is compared on every clock.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // take one serial bit
    logic commit;   // publish the captured word
  } rxCtl_t;

endpackage

// File: rtl/cwr_sync.sv
module cwr_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= RESET_VAL;
          else       pipe[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= RESET_VAL;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/cwr_ctrl.sv
module cwr_ctrl
  import cwr_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sckS,
  input  logic   csnS,
  output rxCtl_t ctl
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_BITS + 1);

  logic             sckPrev;
  logic             csnPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             sckRise;
  logic             csnRise;

  assign sckRise = sckS & ~sckPrev;
  assign csnRise = csnS & ~csnPrev;

  always_comb begin
    ctl.shiftEn = sckRise & ~csnS;
    ctl.commit  = csnRise & (bitCnt == FULL_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csnPrev <= 1'b1;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckS;
      csnPrev <= csnS;
      if (csnS)
        bitCnt <= '0;
      else if (ctl.shiftEn && bitCnt != OVER_CNT)
        bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/cwr_dp.sv
module cwr_dp
  import cwr_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int OP_BITS = 4,
  parameter int MODE_BITS = 8,
  parameter logic [OP_BITS-1:0] CFG_OPCODE = 4'h1,
  parameter logic [MODE_BITS-1:0] MODE_OFF = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rxCtl_t                         ctl,
  input  logic                           bitIn,
  output logic [OP_BITS-1:0]             cmdOut,
  output logic [FRAME_BITS-OP_BITS-1:0]  dataOut,
  output logic [MODE_BITS-1:0]           modeOut,
  output logic                           wordValid,
  output logic                           cfgStrobe
);

  localparam int DATA_BITS = FRAME_BITS - OP_BITS;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [OP_BITS-1:0]    opField;
  logic                  isCfg;

  assign opField = shiftReg[FRAME_BITS-1 -: OP_BITS];
  assign isCfg   = (opField == CFG_OPCODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOut    <= '0;
      dataOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= ctl.commit;
      if (ctl.commit) begin
        cmdOut  <= opField;
        dataOut <= shiftReg[DATA_BITS-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeOut   <= MODE_OFF;
      cfgStrobe <= 1'b0;
    end else begin
      cfgStrobe <= ctl.commit & isCfg;
      if (ctl.commit && isCfg) modeOut <= shiftReg[MODE_BITS-1:0];
    end
  end

endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx
  import cwr_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int OP_BITS = 4,
  parameter int MODE_BITS = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [OP_BITS-1:0] CFG_OPCODE = 4'h1,
  parameter logic [MODE_BITS-1:0] MODE_OFF = '0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sckIn,
  input  logic                          mosiIn,
  input  logic                          csnIn,
  output logic [OP_BITS-1:0]            cmdOut,
  output logic [FRAME_BITS-OP_BITS-1:0] dataOut,
  output logic [MODE_BITS-1:0]          modeOut,
  output logic                          wordValid,
  output logic                          cfgStrobe
);

  // {csn, mosi, sck}; idle levels are csn high, others low
  localparam logic [2:0] PIN_IDLE = 3'b100;

  logic [2:0] pinSync;
  rxCtl_t     ctl;

  cwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({csnIn, mosiIn, sckIn}),
    .syncOut(pinSync)
  );

  cwr_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .sckS(pinSync[0]), .csnS(pinSync[2]),
    .ctl(ctl)
  );

  cwr_dp #(
    .FRAME_BITS(FRAME_BITS), .OP_BITS(OP_BITS), .MODE_BITS(MODE_BITS),
    .CFG_OPCODE(CFG_OPCODE), .MODE_OFF(MODE_OFF)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIn(pinSync[1]),
    .cmdOut(cmdOut), .dataOut(dataOut), .modeOut(modeOut),
    .wordValid(wordValid), .cfgStrobe(cfgStrobe)
  );

endmodule

// File: rtl/cwr_checker.sv
module cwr_checker #(
  parameter int FRAME_BITS = 16,
  parameter int OP_BITS = 4,
  parameter int MODE_BITS = 8,
  parameter logic [OP_BITS-1:0] CFG_OPCODE = 4'h1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [OP_BITS-1:0]            cmdOut,
  input logic [FRAME_BITS-OP_BITS-1:0] dataOut,
  input logic [MODE_BITS-1:0]          modeOut,
  input logic                          wordValid,
  input logic                          cfgStrobe
);

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> ($stable(cmdOut) && $stable(dataOut)));

  p_cfg_with_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> (wordValid && cmdOut == CFG_OPCODE));

  p_mode_from_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> (modeOut == dataOut[MODE_BITS-1:0]));

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgStrobe |-> $stable(modeOut));

  p_cfg_only_opcode_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cmdOut != CFG_OPCODE) |-> !cfgStrobe);

endmodule

bind cmd_word_rx cwr_checker #(
  .FRAME_BITS(FRAME_BITS), .OP_BITS(OP_BITS),
  .MODE_BITS(MODE_BITS), .CFG_OPCODE(CFG_OPCODE)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdOut(cmdOut), .dataOut(dataOut),
  .modeOut(modeOut), .wordValid(wordValid), .cfgStrobe(cfgStrobe)
);

// File: tb/cmd_word_rx_tb_top.sv
module cmd_word_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0;
  logic mosiIn = 1'b0;
  logic csnIn = 1'b1;
  logic [3:0]  cmdOut;
  logic [11:0] dataOut;
  logic [7:0]  modeOut;
  logic wordValid, cfgStrobe;

  always #5 clk = ~clk;

  cmd_word_rx dut_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .csnIn(csnIn),
    .cmdOut(cmdOut), .dataOut(dataOut), .modeOut(modeOut),
    .wordValid(wordValid), .cfgStrobe(cfgStrobe)
  );

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: the design sees pins two edges late
  logic [3:0] hS, hM, hC;
  int   mCount;
  logic [15:0] mShift;
  logic [3:0]  eCmd;
  logic [11:0] eData;
  logic [7:0]  eMode;
  logic eValid, eCfg;

  always @(posedge clk) begin
    if (!rstN) begin
      hS = 4'h0; hM = 4'h0; hC = 4'hF;
      mCount = 0; mShift = 16'h0;
      eCmd = 4'h0; eData = 12'h0; eMode = 8'h00; eValid = 0; eCfg = 0;
    end else begin
      hS = {hS[2:0], sckIn};
      hM = {hM[2:0], mosiIn};
      hC = {hC[2:0], csnIn};
      eValid = 0; eCfg = 0;
      if (hC[2] && !hC[3] && mCount == 16) begin
        eValid = 1;
        eCmd = mShift[15:12];
        eData = mShift[11:0];
        if (mShift[15:12] == 4'h1) begin
          eCfg = 1;
          eMode = mShift[7:0];
        end
      end
      if (hC[2]) mCount = 0;
      else if (hS[2] && !hS[3]) begin
        mShift = {mShift[14:0], hM[2]};
        if (mCount < 17) mCount++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3", "wordValid model", {31'h0, wordValid}, {31'h0, eValid});
      check("R5", "cfgStrobe model", {31'h0, cfgStrobe}, {31'h0, eCfg});
      check("R2", "cmdOut model", {28'h0, cmdOut}, {28'h0, eCmd});
      check("R2", "dataOut model", {20'h0, dataOut}, {20'h0, eData});
      check("R5", "modeOut model", {24'h0, modeOut}, {24'h0, eMode});
    end
  end

  int lastLatency;
  int validCnt;
  int cfgCnt;

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // serial clock half period = 4 system cycles
  task automatic sendFrame(input int nBits, input logic [31:0] bits);
    @(negedge clk);
    csnIn = 1'b0;
    waitClk(4);
    for (int b = nBits - 1; b >= 0; b--) begin
      mosiIn = bits[b];
      waitClk(4);
      sckIn = 1'b1;
      waitClk(4);
      sckIn = 1'b0;
    end
    waitClk(4);
    csnIn = 1'b1;
    lastLatency = 0; validCnt = 0; cfgCnt = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (wordValid) begin
        validCnt++;
        if (lastLatency == 0) lastLatency = i;
      end
      if (cfgStrobe) cfgCnt++;
    end
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    check("R1", "modeOut after reset", {24'h0, modeOut}, 32'h00);
    check("R1", "cmdOut after reset", {28'h0, cmdOut}, 32'h0);
    check("R1", "dataOut after reset", {20'h0, dataOut}, 32'h0);
    check("R1", "strobes after reset", {30'h0, wordValid, cfgStrobe}, 32'h0);

    // R2 R3 R5: configuration write, opcode 1 operand 0x0A5
    sendFrame(16, 32'h10A5);
    check("R2", "cmd of 0x10A5", {28'h0, cmdOut}, 32'h1);
    check("R2", "data of 0x10A5", {20'h0, dataOut}, 32'h0A5);
    check("R5", "mode load", {24'h0, modeOut}, 32'hA5);
    check("R3", "valid pulse count", validCnt, 1);
    check("R3", "valid latency", lastLatency, 3);
    check("R5", "cfg pulse count", cfgCnt, 1);

    // R6: other opcode
    sendFrame(16, 32'h7C3C);
    check("R6", "cmd of 0x7C3C", {28'h0, cmdOut}, 32'h7);
    check("R6", "data of 0x7C3C", {20'h0, dataOut}, 32'hC3C);
    check("R6", "mode held", {24'h0, modeOut}, 32'hA5);
    check("R6", "valid pulse", validCnt, 1);
    check("R6", "no cfg pulse", cfgCnt, 0);

    // R4: short window
    sendFrame(15, 32'h0123);
    check("R4", "short: no valid", validCnt, 0);
    check("R4", "short: cmd held", {28'h0, cmdOut}, 32'h7);
    check("R4", "short: data held", {20'h0, dataOut}, 32'hC3C);

    // R4: long window, opcode 1 in the last 16 bits
    sendFrame(17, 32'h110FF);
    check("R4", "long: no valid", validCnt, 0);
    check("R4", "long: no cfg", cfgCnt, 0);
    check("R4", "long: mode held", {24'h0, modeOut}, 32'hA5);

    // R7: serial clock activity while deselected
    for (int k = 0; k < 5; k++) begin
      mosiIn = 1'b1; waitClk(4); sckIn = 1'b1; waitClk(4); sckIn = 1'b0;
    end
    waitClk(8);
    check("R7", "no valid while deselected", {31'h0, wordValid}, 32'h0);
    sendFrame(16, 32'h105A);
    check("R7", "clean word after idle clocks", {20'h0, dataOut}, 32'h05A);
    check("R7", "mode after idle clocks", {24'h0, modeOut}, 32'h5A);

    // R5: upper operand bits are not part of the mode; off value restored
    sendFrame(16, 32'h1F00);
    check("R5", "mode back to off", {24'h0, modeOut}, 32'h00);
    check("R5", "cfg pulse", cfgCnt, 1);

    // R2: all ones
    sendFrame(16, 32'hFFFF);
    check("R2", "cmd all ones", {28'h0, cmdOut}, 32'hF);
    check("R2", "data all ones", {20'h0, dataOut}, 32'hFFF);
    check("R8", "mode untouched", {24'h0, modeOut}, 32'h00);

    waitClk(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule